// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter that software must service by writing a fixed key byte to a service register. A service is only legal late in each timeout period: the period starts with a closed stretch and ends with an open window. The size of the open window and the length of the period come from static option inputs. Those inputs are sampled as levels and must be stable while the block is out of reset. A correct key written inside the open window restarts the count from zero. A key written too early, any other byte value, or the end of the period without a legal service produces a one-cycle internal reset request. After that request the block freezes until the system reset that follows.

The first service after reset is special. It is accepted at any count before the period runs out, and window checking starts only after it. A combinational status byte tells software whether that first service has happened. One combination of option values is forbidden. The block flags it and treats it as a fault.

Top module: `win_watchdog`

## Requirements
- R1: During and right after synchronous reset, `rst_req` is 0, `cfg_err` follows the options, `stat_data` is 0x9A and the count starts at 0.
- R2: With no accepted service, `rst_req` pulses exactly T clock edges after the reset or service edge. T = 2^(10 + `ovf_sel` - `SCALE_SHIFT`).
- R3: The open window starts at count T - W. W is T/4 for `win_sel`=00, T/2 for 01, 3T/4 for 10 and T for 11. A key byte 0xAC written at a count inside the window restarts counting from 0.
- R4: After the first service, a key write at a count below T - W raises `rst_req` on the next cycle.
- R5: The first write after reset, if it is 0xAC and comes at any count up to T-1, is accepted whatever the window.
- R6: A write of any value other than 0xAC raises `rst_req`, and this also holds for the first write.
- R7: `rst_req` is high for exactly one cycle. After it, writes are ignored, no further request appears and the status stays frozen until reset.
- R8: `stat_data` is 0x9A before the first accepted service and 0x9B after it (bit 0 = first service done).
- R9: `ovf_sel`=000 together with `win_sel`=00 is forbidden. In that case `cfg_err` is 1 and `rst_req` pulses on the first edge after reset.
- R10: A key write at count T-1 inside the window is accepted as a service, and no overflow request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | 8 | Byte written to the service register |
| ovf_sel | input | 3 | Static period select |
| win_sel | input | 2 | Static open-window size select |
| stat_data | output | 8 | Status byte read from the service register |
| cfg_err | output | 1 | Forbidden option combination present |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The key collision is between a service write and the period overflow: both can land on the terminal count T-1. The bench provokes this by idling until the count reaches T-1 and writing the key on that edge. It then judges the result by looking for no request on that edge and by a full fresh period T before the next overflow pulse. The bench also overlaps the halt with a later key write and checks that no second pulse follows. It sweeps every legal option pair at a reduced scale and computes T and the window start arithmetically.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int OVF_BASE_LOG = 10;
    localparam int OVF_SEL_W    = 3;
    localparam int WIN_SEL_W    = 2;
    localparam int CNT_W        = OVF_BASE_LOG + (1 << OVF_SEL_W);
    localparam logic [7:0] SERVICE_KEY = 8'hAC;
    localparam logic [7:0] STAT_BASE   = 8'h9A;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } wdg_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] last;
        logic [CNT_W-1:0] open_start;
        logic             bad;
    } wdg_limits_t;

    function automatic logic [CNT_W-1:0] period_len(
        input logic [OVF_SEL_W-1:0] sel,
        input int                   scale
    );
        logic [CNT_W-1:0] one;
        int               sh;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        sh  = OVF_BASE_LOG + int'(sel) - scale;
        return one << sh;
    endfunction

    function automatic logic [CNT_W-1:0] open_len(
        input logic [CNT_W-1:0]     t,
        input logic [WIN_SEL_W-1:0] win
    );
        case (win)
            2'b00:   return t >> 2;
            2'b01:   return t >> 1;
            2'b10:   return (t >> 1) + (t >> 2);
            default: return t;
        endcase
    endfunction

endpackage

// File: rtl/wdg_limits.sv
module wdg_limits
    import wdg_pkg::*;
#(
    parameter int SCALE_SHIFT = 0
) (
    input  logic [OVF_SEL_W-1:0] ovf_sel,
    input  logic [WIN_SEL_W-1:0] win_sel,
    output wdg_limits_t          lim
);
    logic [CNT_W-1:0] t_len;
    logic [CNT_W-1:0] w_len;

    always_comb begin
        t_len          = period_len(ovf_sel, SCALE_SHIFT);
        w_len          = open_len(t_len, win_sel);
        lim.last       = t_len - CNT_W'(1);
        lim.open_start = t_len - w_len;
        lim.bad        = (ovf_sel == '0) && (win_sel == '0);
    end

    // R3: the window must start inside the period
    always_comb begin
        assert_window_inside_R3: assert (lim.open_start <= lim.last);
    end

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  wdg_limits_t lim,
    output logic        first_done,
    output logic        rst_req
);
    wdg_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             key_ok;
    logic             in_open;
    logic             at_end;
    logic             run;
    logic             fire;
    logic             service;

    always_comb begin
        run     = (state == ST_RUN);
        key_ok  = (wr_data == SERVICE_KEY);
        in_open = (cnt >= lim.open_start);
        at_end  = (cnt == lim.last);
        service = run && !lim.bad && wr_en && key_ok && (!first_done || in_open);
        fire    = run && (lim.bad
                          || (wr_en && (!key_ok || (first_done && !in_open)))
                          || (!wr_en && at_end));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            cnt        <= '0;
            first_done <= 1'b0;
            rst_req    <= 1'b0;
        end else begin
            rst_req <= fire;
            if (fire) begin
                state <= ST_HALT;
            end else if (service) begin
                cnt        <= '0;
                first_done <= 1'b1;
            end else if (run) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R7: request is a single-cycle pulse
    assert_req_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R7: frozen after the request
    assert_halt_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |=> ($stable(cnt) && $stable(first_done) && !rst_req));

    // R2: the count never passes the terminal value
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim.last);

    // R4: early key after the first service is a fault
    assert_closed_key_R4: assert property (@(posedge clk) disable iff (rst)
        (run && first_done && wr_en && key_ok && (cnt < lim.open_start)) |=> rst_req);

    // R3: accepted service restarts from zero
    assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        service |=> (cnt == '0 && first_done));

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wdg_pkg::*;
#(
    parameter int SCALE_SHIFT = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    input  logic [OVF_SEL_W-1:0] ovf_sel,
    input  logic [WIN_SEL_W-1:0] win_sel,
    output logic [7:0]           stat_data,
    output logic                 cfg_err,
    output logic                 rst_req
);
    wdg_limits_t lim;
    logic        first_done;

    wdg_limits #(.SCALE_SHIFT(SCALE_SHIFT)) u_limits (
        .ovf_sel (ovf_sel),
        .win_sel (win_sel),
        .lim     (lim)
    );

    wdg_core u_core (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .lim        (lim),
        .first_done (first_done),
        .rst_req    (rst_req)
    );

    assign cfg_err   = lim.bad;
    assign stat_data = STAT_BASE | {7'd0, first_done};

endmodule

// File: tb/test_win_watchdog.sv
`timescale 1ns/1ps
module test_win_watchdog;
    localparam int SCALE = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] ovf_sel = 3'd1;
    logic [1:0] win_sel = 2'd0;
    logic [7:0] stat_data;
    logic       cfg_err;
    logic       rst_req;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    win_watchdog #(.SCALE_SHIFT(SCALE)) i_win_watchdog (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ovf_sel   (ovf_sel),
        .win_sel   (win_sel),
        .stat_data (stat_data),
        .cfg_err   (cfg_err),
        .rst_req   (rst_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h (ovf=%0d win=%0d)",
                     tag, act, exp, ovf_sel, win_sel);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        while (!done && cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int o = 0; o < 8; o++) begin
            for (int w = 0; w < 4; w++) begin
                int t;
                int start;
                if (o == 0 && w == 0) continue;
                ovf_sel = 3'(o);
                win_sel = 2'(w);
                t = 1 << (10 + o - SCALE);
                start = t - (t / 4) * (w + 1);
                do_reset();
                chk(rst_req == 1'b0, "R1 req after reset", rst_req, 0);
                chk(stat_data == 8'h9A, "R1/R8 status after reset", stat_data, 8'h9A);
                chk(cfg_err == 1'b0, "R1 cfg_err legal", cfg_err, 0);
                // first service at count 3, window ignored
                idle(3);
                wr(8'hAC);
                chk(rst_req == 1'b0, "R5 first service early", rst_req, 0);
                chk(stat_data == 8'h9B, "R8 status after service", stat_data, 8'h9B);
                // service at window start
                idle(start);
                wr(8'hAC);
                chk(rst_req == 1'b0, "R3 service at window start", rst_req, 0);
                // service on the terminal count
                idle(t - 1);
                wr(8'hAC);
                chk(rst_req == 1'b0, "R10 service at T-1", rst_req, 0);
                // overflow
                idle(t - 1);
                chk(rst_req == 1'b0, "R2 no request before T", rst_req, 0);
                idle(1);
                chk(rst_req == 1'b1, "R2 overflow request", rst_req, 1);
                idle(1);
                chk(rst_req == 1'b0, "R7 pulse one cycle", rst_req, 0);
                wr(8'hAC);
                idle(t + 2);
                chk(rst_req == 1'b0, "R7 halted ignores writes", rst_req, 0);
                chk(stat_data == 8'h9B, "R7 status frozen", stat_data, 8'h9B);
                // early key after first service
                if (start > 0) begin
                    do_reset();
                    wr(8'hAC);
                    idle(start - 1);
                    wr(8'hAC);
                    chk(rst_req == 1'b1, "R4 key in closed window", rst_req, 1);
                end
                // wrong key as first write
                do_reset();
                idle(1);
                wr(8'h55);
                chk(rst_req == 1'b1, "R6 wrong key first write", rst_req, 1);
                chk(stat_data == 8'h9A, "R6/R8 status unchanged", stat_data, 8'h9A);
                // wrong key inside window after service
                do_reset();
                wr(8'hAC);
                idle(t - 1);
                wr(8'hCA);
                chk(rst_req == 1'b1, "R6 wrong key in window", rst_req, 1);
                // first write on terminal count
                do_reset();
                idle(t - 1);
                wr(8'hAC);
                chk(rst_req == 1'b0, "R5 first service at T-1", rst_req, 0);
            end
        end
        // forbidden combination
        ovf_sel = 3'd0;
        win_sel = 2'd0;
        do_reset();
        chk(cfg_err == 1'b1, "R9 cfg_err flagged", cfg_err, 1);
        chk(rst_req == 1'b0, "R9 no request before edge", rst_req, 0);
        idle(1);
        chk(rst_req == 1'b1, "R9 request on first edge", rst_req, 1);
        idle(1);
        chk(rst_req == 1'b0, "R9/R7 single pulse", rst_req, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule